// File: doc/BRIEF.md
# Local Bus Cycle Timeout Monitor

This block guards the on-board data transfer path against cycles that never finish. The targets it watches include on-board I/O, mezzanine modules and dual-ported memory. While a cycle strobe is active, a counter runs. If the cycle is not closed by a normal acknowledge before the counter reaches its limit, the block raises a bus error that ends the cycle. The limit is 128 microseconds by default, computed from a clock frequency parameter. A sticky status flag records that the error came from this timer, so software can tell it apart from other bus error sources.

For transfers that need the external system bus, only the wait for bus ownership is timed. The counter runs from the start of the request, and a grant while the request is raised stops it. The rest of that cycle belongs to a separate external-bus monitor. A control/status register provides an enable bit and a clear strobe for the status flag.

Top module: `bus_cycle_watch`

## Requirements
- R1: While `rst_i` is high, and on the first edge after it is released, `bus_err_o` and `tmo_flag_o` are 0.
- R2: The limit is TICKS = (CLK_HZ/1000)*TIMEOUT_US/1000 clock ticks (6400 ticks for 128 us at 50 MHz). Take a cycle whose strobe `cyc_active_i` is first sampled high at edge E0, with the block enabled and no acknowledge or grant. `bus_err_o` is 0 after edge E(TICKS-1) and 1 after edge E(TICKS).
- R3: An acknowledge `cyc_ack_i` sampled at any edge up to and including E(TICKS) ends timing. No bus error follows for the rest of that cycle, however long the strobe stays high.
- R4: Once raised, `bus_err_o` stays high while the strobe stays high. It returns to 0 on the first edge that samples the strobe low.
- R5: With `mon_enable_i` low, `bus_err_o` is never raised. Dropping the enable while the error is high clears the error on the next edge.
- R6: `tmo_flag_o` is set on the same edge that raises `bus_err_o`.
- R7: `tmo_flag_o` stays set until `stat_clear_i` is sampled high, and it is 0 after that edge.
- R8: If a clear and a new timeout land on the same edge, `tmo_flag_o` is 1 after that edge.
- R9: While `xbus_req_i` is high, a grant `xbus_grant_i` sampled before the limit stops and clears the counter. No bus error follows for the rest of that cycle.
- R10: If `xbus_req_i` is high and no grant arrives, the request-to-grant gap is timed like any cycle. The error comes at E(TICKS).
- R11: A strobe that drops and rises again starts a fresh count from zero. Time spent in the earlier cycle does not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mon_enable_i | input | 1 | Timer enable from the control/status register |
| stat_clear_i | input | 1 | Clear strobe for the timeout status flag |
| cyc_active_i | input | 1 | A data transfer cycle is in progress |
| cyc_ack_i | input | 1 | The cycle ended normally |
| xbus_req_i | input | 1 | The cycle is waiting for external-bus ownership |
| xbus_grant_i | input | 1 | External-bus ownership has been granted |
| bus_err_o | output | 1 | Bus error, held until the strobe drops |
| tmo_flag_o | output | 1 | Sticky flag: a bus error was raised by this timer |

## Verification
Two pairs of events can fall on the same clock edge. The first is a normal acknowledge or grant against the counter expiring. The bench places the acknowledge on exactly edge E(TICKS) and expects no error. A bare cycle of the same length must raise the error on that edge, which pins the limit from both sides. The second pair is a software clear of the status flag against a new timeout. The bench raises the clear on the same edge as the expiry and expects the flag to read set afterwards.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ERR   = 2'd2,
    ST_DRAIN = 2'd3
  } bcw_state_e;

  function automatic int unsigned bcw_ticks(input int unsigned clk_hz,
                                            input int unsigned limit_us);
    return (clk_hz / 1000) * limit_us / 1000;
  endfunction

endpackage

// File: rtl/bcw_tick_counter.sv
module bcw_tick_counter #(
  parameter int unsigned TICKS = 6400,
  localparam int unsigned CNT_W = (TICKS > 2) ? $clog2(TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = (cnt_q == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST)
    else $error("R2: counter passed its limit");

  p_cnt_cleared_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> (cnt_q == '0))
    else $error("R11: counter not cleared");

endmodule

// File: rtl/bcw_seq_ctrl.sv
module bcw_seq_ctrl
  import bcw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic active_i,
  input  logic ack_i,
  input  logic req_i,
  input  logic grant_i,
  input  logic expire_i,
  output logic cnt_clear_o,
  output logic cnt_run_o,
  output logic err_set_o,
  output logic bus_err_o
);

  bcw_state_e state_q, state_d;
  logic       handoff;
  logic       done_ok;

  assign handoff = req_i && grant_i;
  assign done_ok = ack_i || handoff;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i && active_i) begin
          state_d = done_ok ? ST_DRAIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (!en_i || !active_i) begin
          state_d = ST_IDLE;
        end else if (done_ok) begin
          state_d = ST_DRAIN;
        end else if (expire_i) begin
          state_d = ST_ERR;
        end
      end
      ST_ERR: begin
        if (!en_i || !active_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (!en_i || !active_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q   <= ST_IDLE;
      bus_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      bus_err_o <= (state_d == ST_ERR);
    end
  end

  assign cnt_clear_o = (state_q != ST_RUN);
  assign cnt_run_o   = (state_q == ST_RUN);
  assign err_set_o   = (state_q != ST_ERR) && (state_d == ST_ERR);

  p_err_needs_en_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !bus_err_o)
    else $error("R5: bus error while disabled");

  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_err_o && active_i && en_i) |=> bus_err_o)
    else $error("R4: bus error dropped early");

  p_err_drop_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_err_o && !active_i) |=> !bus_err_o)
    else $error("R4: bus error outlived the strobe");

  p_ack_no_err_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_RUN && ack_i) |=> !bus_err_o)
    else $error("R3: bus error after acknowledge");

  p_handoff_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_DRAIN) |=> !bus_err_o)
    else $error("R9: bus error after grant or ack");

endmodule

// File: rtl/bcw_sticky_flag.sv
module bcw_sticky_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end else if (clear_i) begin
      flag_o <= 1'b0;
    end
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> flag_o)
    else $error("R8: set lost against clear");

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_o && !clear_i) |=> flag_o)
    else $error("R7: flag dropped without clear");

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && !set_i) |=> !flag_o)
    else $error("R7: clear ignored");

endmodule

// File: rtl/bus_cycle_watch.sv
module bus_cycle_watch
  import bcw_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned TIMEOUT_US = 128,
  localparam int unsigned TICKS     = bcw_ticks(CLK_HZ, TIMEOUT_US)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mon_enable_i,
  input  logic stat_clear_i,
  input  logic cyc_active_i,
  input  logic cyc_ack_i,
  input  logic xbus_req_i,
  input  logic xbus_grant_i,
  output logic bus_err_o,
  output logic tmo_flag_o
);

  initial begin
    if (TICKS < 2) $error("timeout must span at least two clock ticks");
  end

  logic cnt_clear;
  logic cnt_run;
  logic expire;
  logic err_set;

  bcw_tick_counter #(
    .TICKS(TICKS)
  ) counter_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (cnt_clear),
    .run_i   (cnt_run),
    .expire_o(expire)
  );

  bcw_seq_ctrl ctrl_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (mon_enable_i),
    .active_i   (cyc_active_i),
    .ack_i      (cyc_ack_i),
    .req_i      (xbus_req_i),
    .grant_i    (xbus_grant_i),
    .expire_i   (expire),
    .cnt_clear_o(cnt_clear),
    .cnt_run_o  (cnt_run),
    .err_set_o  (err_set),
    .bus_err_o  (bus_err_o)
  );

  bcw_sticky_flag flag_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (err_set),
    .clear_i(stat_clear_i),
    .flag_o (tmo_flag_o)
  );

  p_flag_with_err_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(bus_err_o) |-> tmo_flag_o)
    else $error("R6: flag missing when bus error rose");

endmodule

// File: tb/bus_cycle_watch_tb_top.sv
module bus_cycle_watch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned LIM_US = 16;
  localparam int T = (CLK_HZ / 1000) * LIM_US / 1000;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst, en, clr, strobe, ack, req, grant;
  logic bus_err, tmo_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_watch #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(LIM_US)) dut_i (
    .clk_i(clk), .rst_i(rst), .mon_enable_i(en), .stat_clear_i(clr),
    .cyc_active_i(strobe), .cyc_ack_i(ack), .xbus_req_i(req),
    .xbus_grant_i(grant), .bus_err_o(bus_err), .tmo_flag_o(tmo_flag)
  );

  typedef struct {
    int    due;
    logic  err;
    logic  flag;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops every expectation that falls due at this sample point
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        total++;
        if (bus_err !== sb_q[i].err || tmo_flag !== sb_q[i].flag) begin
          bad++;
          $display("FAIL %s: err/flag actual=%b/%b expected=%b/%b",
                   sb_q[i].tag, bus_err, tmo_flag, sb_q[i].err, sb_q[i].flag);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic expect_in(input int d, input logic e, input logic f, input string tag);
    exp_t it;
    it.due = cyc + d; it.err = e; it.flag = f; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic adv(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 1; clr = 0; strobe = 0; ack = 0; req = 0; grant = 0;
    adv(3);
    expect_in(1, 0, 0, "R1 in reset");
    adv(1);
    rst = 0;
    expect_in(1, 0, 0, "R1 after release");
    adv(2);

    // plain timeout, hold, release, sticky flag, clear
    strobe = 1;
    expect_in(T, 0, 0, "R2 one tick early");
    expect_in(T + 1, 1, 1, "R2 R6 expiry");
    adv(T + 3);
    expect_in(1, 1, 1, "R4 hold");
    adv(1);
    strobe = 0;
    expect_in(1, 0, 1, "R4 release");
    adv(6);
    expect_in(1, 0, 1, "R7 sticky");
    adv(1);
    clr = 1;
    expect_in(1, 0, 0, "R7 clear");
    adv(1);
    clr = 0;
    adv(2);

    // acknowledge well before the limit
    strobe = 1;
    adv(5);
    ack = 1;
    adv(1);
    ack = 0;
    expect_in(3 * T, 0, 0, "R3 early ack");
    adv(3 * T + 1);
    strobe = 0;
    adv(2);

    // acknowledge on the expiry edge itself
    strobe = 1;
    adv(T);
    ack = 1;
    expect_in(1, 0, 0, "R3 ack at limit");
    adv(1);
    ack = 0;
    expect_in(T, 0, 0, "R3 after ack at limit");
    adv(T + 1);
    strobe = 0;
    adv(2);

    // external bus: grant before the limit
    strobe = 1; req = 1;
    adv(T - 2);
    grant = 1;
    adv(1);
    grant = 0;
    expect_in(3 * T, 0, 0, "R9 after grant");
    adv(3 * T + 1);
    strobe = 0; req = 0;
    adv(2);

    // external bus: no grant
    strobe = 1; req = 1;
    expect_in(T, 0, 0, "R10 early");
    expect_in(T + 1, 1, 1, "R10 expiry");
    adv(T + 2);
    strobe = 0; req = 0;
    expect_in(1, 0, 1, "R4 release xbus");
    adv(2);
    clr = 1;
    expect_in(1, 0, 0, "R7 clear again");
    adv(1);
    clr = 0;

    // disabled
    en = 0;
    strobe = 1;
    expect_in(3 * T, 0, 0, "R5 disabled");
    adv(3 * T + 1);
    strobe = 0;
    adv(2);
    en = 1;
    adv(1);
    strobe = 1;
    expect_in(T + 1, 1, 1, "R2 before disable");
    adv(T + 2);
    en = 0;
    expect_in(1, 0, 1, "R5 disable drops error");
    adv(1);
    strobe = 0; en = 1;
    adv(2);

    // clear and timeout on the same edge (flag was set above)
    strobe = 1;
    adv(T);
    clr = 1;
    expect_in(1, 1, 1, "R8 clear vs set");
    adv(1);
    clr = 0;
    expect_in(1, 1, 1, "R8 stays set");
    adv(1);
    strobe = 0;
    adv(2);
    clr = 1;
    adv(1);
    clr = 0;

    // back-to-back cycles restart the count
    strobe = 1;
    adv(T - 2);
    strobe = 0;
    adv(1);
    strobe = 1;
    expect_in(T, 0, 0, "R11 fresh count");
    expect_in(T + 1, 1, 1, "R11 expiry");
    adv(T + 2);
    strobe = 0;
    adv(3);

    if (sb_q.size() != 0) begin
      bad += sb_q.size();
      total += sb_q.size();
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule